// File: doc/BRIEF.md
# Transmit Rate Divider and Configuration Registers

This block holds the two transmit configuration words that a control processor writes through a parallel write strobe: an 8-bit word and a 16-bit word at adjacent addresses. Each write is split into fields at once. Every field that holds a rate is turned into the ratio it stands for, where an all-zero field stands for the largest ratio. The decoded fields go straight out to the transmit datapath: filter bandwidth select, first-stage bypass, interpolation filter length and the three rates.

From the master clock the block makes three clock-enable strobes. Each strobe is one master-clock cycle wide. The modulator-rate enable fires once every N master cycles. The upsampled-data enable fires once every L2 modulator enables. The first-stage enable fires once every L1 upsampled-data enables, and it stays low while the first stage is bypassed. A write to either register restarts all three counters, so the new rates start from a clean phase.

Top module: `tx_clk_cfg`

## Requirements
- R1: After reset the outputs read bw_hi=0, bypass=0, mod_ratio=128, l2_ratio=32, l1_ratio=8 and flen=128, and all three enables are low.
- R2: A write to address 0x30 takes only wr_data[7:0]. Bit 7 drives bw_hi and bits 6:0 are the modulator divide field. wr_data[15:8] has no effect.
- R3: A write to address 0x31 decodes as follows: bits 15:11 are the second-rate field, bit 10 is bypass, bits 9:3 are the filter-length field and bits 2:0 are the first-rate field. The decoded values appear on the outputs in the cycle after the write edge.
- R4: A write to any other address changes no output and does not disturb the enable phase.
- R5: The modulator divide field decodes with 0 as 128 and 1 as 2; any other value stands for itself. mod_en is high for one cycle in every mod_ratio cycles.
- R6: The second-rate field decodes with 0 as 32. s2_en fires one cycle after every l2_ratio-th mod_en pulse.
- R7: The first-rate field decodes with 0 as 8, and the filter-length field decodes with 0 as 128. s1_en fires one cycle after every l1_ratio-th s2_en pulse.
- R8: While bypass is 1, s1_en stays low.
- R9: A write to address 0x30 or 0x31 clears all counters and all enables. Counting from the write edge w, mod_en is first seen after edge w+N, s2_en after edge w+L2·N+1 and s1_en after edge w+L1·L2·N+2.
- R10: No enable is ever high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data (8-bit register uses bits 7:0) |
| bw_hi | output | 1 | High-bandwidth filter select |
| bypass | output | 1 | First-stage bypass |
| flen | output | 8 | Interpolation filter length, 1 to 128 |
| l1_ratio | output | 4 | First upsample rate, 1 to 8 |
| l2_ratio | output | 6 | Second upsample rate, 1 to 32 |
| mod_ratio | output | 8 | Master-to-modulator divide, 2 to 128 |
| mod_en | output | 1 | Modulator-rate enable pulse |
| s2_en | output | 1 | Upsampled-data enable pulse |
| s1_en | output | 1 | First-stage enable pulse |

## Verification
The assertions check on every cycle the properties that hold for any cycle. Each pulse lasts one cycle. Each s2_en follows a mod_en and each s1_en follows an s2_en. s1_en stays low under bypass. The decoded ratios stay within their ranges. Every decoded write clears the enables, and reset restores the defaults. Only the bench scenarios can show the exact pulse cycles for a given configuration, the restart phase after a write, the zero and one field corners, and that an ignored address or the upper data byte leaves both the outputs and the pulse phase as they were.

// File: rtl/tx_clk_pkg.sv
package tx_clk_pkg;
  // field widths of the raw register fields
  localparam int MODF_W = 7;
  localparam int L2F_W  = 5;
  localparam int L1F_W  = 3;
  localparam int FLF_W  = 7;
  // decoded widths hold the value 2**field_width
  localparam int MODR_W = MODF_W + 1;
  localparam int L2R_W  = L2F_W + 1;
  localparam int L1R_W  = L1F_W + 1;
  localparam int FLR_W  = FLF_W + 1;
  // bit positions inside the written words
  localparam int BW_BIT  = 7;
  localparam int MOD_LSB = 0;
  localparam int L1_LSB  = 0;
  localparam int FL_LSB  = 3;
  localparam int BYP_BIT = 10;
  localparam int L2_LSB  = 11;

  typedef struct packed {
    logic              bw_hi;
    logic              bypass;
    logic [MODR_W-1:0] mod_ratio;
    logic [L2R_W-1:0]  l2_ratio;
    logic [L1R_W-1:0]  l1_ratio;
    logic [FLR_W-1:0]  flen;
  } tx_cfg_t;
endpackage

// File: rtl/tx_zmax_dec.sv
// Turns a rate field into a ratio: zero selects 2**FW, values under MIN_RATIO rise to MIN_RATIO.
module tx_zmax_dec #(
  parameter int FW        = 7,
  parameter int MIN_RATIO = 1
) (
  input  logic [FW-1:0] field,
  output logic [FW:0]   ratio
);
  localparam logic [FW:0] MAXV = (FW+1)'(1) << FW;
  localparam logic [FW:0] MINV = (FW+1)'(MIN_RATIO);

  always_comb begin
    if (field == '0)                  ratio = MAXV;
    else if ({1'b0, field} < MINV)    ratio = MINV;
    else                              ratio = {1'b0, field};
  end
endmodule

// File: rtl/tx_cfg_regs.sv
module tx_cfg_regs
  import tx_clk_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 16,
  parameter logic [AW-1:0] ADDR_CTL0 = 8'h30,
  parameter logic [AW-1:0] ADDR_CTL1 = 8'h31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output tx_cfg_t       cfg,
  output logic          restart
);
  logic hit0, hit1;
  logic [MODR_W-1:0] mod_dec;
  logic [L2R_W-1:0]  l2_dec;
  logic [L1R_W-1:0]  l1_dec;
  logic [FLR_W-1:0]  fl_dec;

  assign hit0    = wr_valid && (wr_addr == ADDR_CTL0);
  assign hit1    = wr_valid && (wr_addr == ADDR_CTL1);
  assign restart = hit0 || hit1;

  tx_zmax_dec #(.FW(MODF_W), .MIN_RATIO(2)) u_dec_mod (
    .field(wr_data[MOD_LSB +: MODF_W]), .ratio(mod_dec));
  tx_zmax_dec #(.FW(L2F_W), .MIN_RATIO(1)) u_dec_l2 (
    .field(wr_data[L2_LSB +: L2F_W]), .ratio(l2_dec));
  tx_zmax_dec #(.FW(L1F_W), .MIN_RATIO(1)) u_dec_l1 (
    .field(wr_data[L1_LSB +: L1F_W]), .ratio(l1_dec));
  tx_zmax_dec #(.FW(FLF_W), .MIN_RATIO(1)) u_dec_fl (
    .field(wr_data[FL_LSB +: FLF_W]), .ratio(fl_dec));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.bw_hi     <= 1'b0;
      cfg.bypass    <= 1'b0;
      cfg.mod_ratio <= MODR_W'(1) << MODF_W;
      cfg.l2_ratio  <= L2R_W'(1) << L2F_W;
      cfg.l1_ratio  <= L1R_W'(1) << L1F_W;
      cfg.flen      <= FLR_W'(1) << FLF_W;
    end else begin
      if (hit0) begin
        cfg.bw_hi     <= wr_data[BW_BIT];
        cfg.mod_ratio <= mod_dec;
      end
      if (hit1) begin
        cfg.bypass   <= wr_data[BYP_BIT];
        cfg.l2_ratio <= l2_dec;
        cfg.l1_ratio <= l1_dec;
        cfg.flen     <= fl_dec;
      end
    end
  end
endmodule

// File: rtl/tx_rate_div.sv
// Counts tick strobes and emits one registered pulse on every ratio-th tick.
module tx_rate_div #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic          hold,
  input  logic [RW-1:0] ratio,
  output logic          pulse
);
  logic [RW-1:0] cnt;
  logic          last;

  assign last = (cnt == ratio - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && last && !hold;
      if (tick) cnt <= last ? '0 : cnt + RW'(1);
    end
  end
endmodule

// File: rtl/tx_clk_cfg.sv
module tx_clk_cfg
  import tx_clk_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] ADDR_CTL0 = 8'h30,
  parameter logic [AW-1:0] ADDR_CTL1 = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              bw_hi,
  output logic              bypass,
  output logic [FLR_W-1:0]  flen,
  output logic [L1R_W-1:0]  l1_ratio,
  output logic [L2R_W-1:0]  l2_ratio,
  output logic [MODR_W-1:0] mod_ratio,
  output logic              mod_en,
  output logic              s2_en,
  output logic              s1_en
);
  tx_cfg_t cfg;
  logic    restart;

  tx_cfg_regs #(.AW(AW), .DW(DW), .ADDR_CTL0(ADDR_CTL0), .ADDR_CTL1(ADDR_CTL1)) u_regs (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .restart(restart));

  // modulator-rate stage runs on every master cycle
  tx_rate_div #(.RW(MODR_W)) u_div_mod (
    .clk(clk), .rst(rst), .restart(restart), .tick(1'b1), .hold(1'b0),
    .ratio(cfg.mod_ratio), .pulse(mod_en));

  // upsampled-data stage counts modulator enables
  tx_rate_div #(.RW(L2R_W)) u_div_s2 (
    .clk(clk), .rst(rst), .restart(restart), .tick(mod_en), .hold(1'b0),
    .ratio(cfg.l2_ratio), .pulse(s2_en));

  // first-stage enable counts upsampled-data enables, silent under bypass
  tx_rate_div #(.RW(L1R_W)) u_div_s1 (
    .clk(clk), .rst(rst), .restart(restart), .tick(s2_en), .hold(cfg.bypass),
    .ratio(cfg.l1_ratio), .pulse(s1_en));

  assign bw_hi     = cfg.bw_hi;
  assign bypass    = cfg.bypass;
  assign flen      = cfg.flen;
  assign l1_ratio  = cfg.l1_ratio;
  assign l2_ratio  = cfg.l2_ratio;
  assign mod_ratio = cfg.mod_ratio;
endmodule

// File: rtl/tx_clk_cfg_chk.sv
module tx_clk_cfg_chk #(
  parameter int            AW = 8,
  parameter logic [AW-1:0] A0 = 8'h30,
  parameter logic [AW-1:0] A1 = 8'h31
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          bw_hi,
  input logic          bypass,
  input logic [7:0]    flen,
  input logic [3:0]    l1_ratio,
  input logic [5:0]    l2_ratio,
  input logic [7:0]    mod_ratio,
  input logic          mod_en,
  input logic          s2_en,
  input logic          s1_en
);
  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    rst |=> (!bw_hi && !bypass && mod_ratio == 8'd128 && l2_ratio == 6'd32 &&
             l1_ratio == 4'd8 && flen == 8'd128 && !mod_en && !s2_en && !s1_en));
  // R5
  mod_range_chk: assert property (@(posedge clk) disable iff (rst)
    mod_ratio >= 8'd2 && mod_ratio <= 8'd128);
  // R6
  s2_follows_mod_chk: assert property (@(posedge clk) disable iff (rst)
    s2_en |-> $past(mod_en));
  // R7
  s1_follows_s2_chk: assert property (@(posedge clk) disable iff (rst)
    s1_en |-> $past(s2_en));
  // R7
  rate_range_chk: assert property (@(posedge clk) disable iff (rst)
    l1_ratio >= 4'd1 && l1_ratio <= 4'd8 && l2_ratio >= 6'd1 && l2_ratio <= 6'd32 &&
    flen >= 8'd1 && flen <= 8'd128);
  // R8
  bypass_silent_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !s1_en);
  // R9
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_addr == A0 || wr_addr == A1)) |=> (!mod_en && !s2_en && !s1_en));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_en || s2_en || s1_en) |=>
      !(mod_en && $past(mod_en)) && !(s2_en && $past(s2_en)) && !(s1_en && $past(s1_en)));
endmodule

bind tx_clk_cfg tx_clk_cfg_chk #(.AW(AW), .A0(ADDR_CTL0), .A1(ADDR_CTL1)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .bw_hi(bw_hi), .bypass(bypass), .flen(flen), .l1_ratio(l1_ratio),
  .l2_ratio(l2_ratio), .mod_ratio(mod_ratio), .mod_en(mod_en),
  .s2_en(s2_en), .s1_en(s1_en));

// File: tb/tb_tx_clk_cfg.sv
module tb_tx_clk_cfg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [15:0] wr_data = 16'h0000;
  logic        bw_hi, bypass, mod_en, s2_en, s1_en;
  logic [7:0]  flen, mod_ratio;
  logic [3:0]  l1_ratio;
  logic [5:0]  l2_ratio;

  int errors = 0;
  int checks = 0;
  int t_edges = 0;
  bit armed = 0;
  int win_lo = 0, win_hi = 0;
  int q_mod[$];
  int q_s2[$];
  int q_s1[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) t_edges <= t_edges + 1;

  tx_clk_cfg dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .bw_hi(bw_hi), .bypass(bypass), .flen(flen), .l1_ratio(l1_ratio),
    .l2_ratio(l2_ratio), .mod_ratio(mod_ratio), .mod_en(mod_en),
    .s2_en(s2_en), .s1_en(s1_en));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int zmax(input int f, input int w);
    return (f == 0) ? (1 << w) : f;
  endfunction

  // monitor: pops expected pulse times and compares
  task automatic pop_cmp(ref int q[$], input string req, input string name, input int t);
    int e;
    if (q.size() == 0) chk(0, req, {"unexpected ", name, " pulse at"}, t, -1);
    else begin
      e = q.pop_front();
      chk(t == e, req, {name, " pulse time"}, t, e);
    end
  endtask

  always @(negedge clk) begin
    if (armed && t_edges > win_lo && t_edges < win_hi) begin
      if (mod_en) pop_cmp(q_mod, "R5", "mod_en", t_edges);
      if (s2_en)  pop_cmp(q_s2,  "R6", "s2_en",  t_edges);
      if (s1_en)  pop_cmp(q_s1,  "R7", "s1_en",  t_edges);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d, output int w);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    w = t_edges + 1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // driver: push expected pulse times in (lo,hi) for phase base w, then let the monitor run
  task automatic window(input int w, input int lo, input int hi,
                        input int n, input int l2, input int l1, input bit byp);
    for (int k = 1; w + k*n < hi; k++)
      if (w + k*n > lo) q_mod.push_back(w + k*n);
    for (int k = 1; w + k*l2*n + 1 < hi; k++)
      if (w + k*l2*n + 1 > lo) q_s2.push_back(w + k*l2*n + 1);
    if (!byp)
      for (int k = 1; w + k*l1*l2*n + 2 < hi; k++)
        if (w + k*l1*l2*n + 2 > lo) q_s1.push_back(w + k*l1*l2*n + 2);
    win_lo = lo; win_hi = hi; armed = 1;
    while (t_edges < hi) @(negedge clk);
    armed = 0;
    chk(q_mod.size() == 0, "R9", "missing mod_en pulses", q_mod.size(), 0);
    chk(q_s2.size() == 0, "R9", "missing s2_en pulses", q_s2.size(), 0);
    chk(q_s1.size() == 0, "R8", "missing s1_en pulses", q_s1.size(), 0);
    q_mod.delete(); q_s2.delete(); q_s1.delete();
  endtask

  task automatic check_fields(input int bw, input int byp, input int n,
                              input int l2, input int l1, input int fl, input string req);
    chk(bw_hi == bw[0], req, "bw_hi", bw_hi, bw);
    chk(bypass == byp[0], req, "bypass", bypass, byp);
    chk(int'(mod_ratio) == n, req, "mod_ratio", mod_ratio, n);
    chk(int'(l2_ratio) == l2, req, "l2_ratio", l2_ratio, l2);
    chk(int'(l1_ratio) == l1, req, "l1_ratio", l1_ratio, l1);
    chk(int'(flen) == fl, req, "flen", flen, fl);
  endtask

  // writes both words and runs a window; fields taken from the written values
  task automatic scenario(input logic [15:0] d0, input logic [15:0] d1, input int span,
                          input string req, output int wbase);
    int w0, w, n, l2, l1, fl, byp;
    wr(8'h30, d0, w0);
    wr(8'h31, d1, w);
    n = zmax(int'(d0[6:0]), 7);
    if (n == 1) n = 2;
    l2 = zmax(int'(d1[15:11]), 5);
    byp = int'(d1[10]);
    fl = zmax(int'(d1[9:3]), 7);
    l1 = zmax(int'(d1[2:0]), 3);
    check_fields(int'(d0[7]), byp, n, l2, l1, fl, req);
    window(w, w, w + span, n, l2, l1, byp[0]);
    wbase = w;
  endtask

  initial begin
    int wb, wi, tnow;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: defaults after reset
    check_fields(0, 0, 128, 32, 8, 128, "R1");
    chk(!mod_en && !s2_en && !s1_en, "R1", "enables low", mod_en, 0);

    // R2 R3 R9: N=3, L2=2, flen=4, L1=3
    scenario(16'h0083, 16'h1023, 120, "R3", wb);
    // R2 upper byte ignored, R5 field 1 -> 2, R6 L2=1, R7 flen 0 -> 128
    scenario(16'hAA81, 16'h0801, 40, "R2", wb);
    // R8: bypass with N=5, L2=3, flen=10, L1=2
    scenario(16'h0005, 16'h1C52, 150, "R8", wb);
    // R4: writes elsewhere change nothing and keep the phase of the last decoded write
    wr(8'h32, 16'hFFFF, wi);
    wr(8'h2F, 16'h0000, wi);
    check_fields(0, 1, 5, 3, 2, 10, "R4");
    tnow = t_edges;
    window(wb, tnow, tnow + 100, 5, 3, 2, 1'b1);
    // R5 R6 R7 R10: all-zero fields decode to maximum ratios
    scenario(16'h0000, 16'h0000, 600, "R7", wb);
    // R9: rewrite mid-period restarts phase, N=7, L2=2, L1=2
    scenario(16'h0007, 16'h1002, 90, "R9", wb);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule